// File: doc/BRIEF.md
# Error-Checking Memory Controller Register Bank

This block is the configuration and fault-reporting register set of a memory controller with error checking. A host reaches it over a plain 32-bit word bus (byte address, write strobe, write data, read strobe, read data). The bank holds nine 32-bit words: an enable/configuration word, a delay word, a fault status word, a video configuration word, two fault address words, a diagnostic word and two event counters. The read path is combinational from the stored state, so the word addressed while the read strobe is high appears in the same cycle. Writes take effect at the next rising clock edge.

The memory datapath reports a detected error through a one-cycle capture pulse. The pulse carries an uncorrectable flag, the double-word index, the syndrome and two address words. The bank stores these fields, raises a level interrupt when the error calls for one, and marks multiple errors when an earlier fault has not yet been cleared. A `VARIANT` parameter chooses one of three controller flavours. The flavour sets the enable-word write mask, which fields survive a soft reset, and whether a four-byte diagnostic window exists.

There are two resets. `rst_n` is an asynchronous power-on reset that loads fixed values. `soft_rst` is a synchronous reset that keeps selected configuration fields.

Top module: `ecc_regbank`

## Requirements
- R1: A word at byte address A is mapped when A[12]=0 and A[11:6]=0, with index A[5:2]: 0 enable, 1 delay, 2 fault status, 3 video config, 4 fault address 0, 5 fault address 1, 6 diagnostic, 7 event count 0, 8 event count 1. Indexes 9 to 15, and every other address, read as zero. `rd_data` is zero whenever `rd_en` is low.
- R2: Bits [31:28] of the enable word hold the variant code (0, 1 or 2). In variant 0 a write stores `wr_data & 0x00000103`. In variants 1 and 2 a write stores `(code<<28) | (wr_data & 0x00000BFF)`.
- R3: A write to the delay word stores `wr_data & 0x7FFFFFFF`, so bit 31 always reads as 0.
- R4: A write to the fault status word stores `wr_data` unchanged and drives `irq` low from the next cycle.
- R5: Bus writes to both fault address words have no effect.
- R6: After `rst_n` the bank reads as follows: enable = code<<28, delay = 0x00000020, fault address 0 = 0x07C00000, every other word 0, diagnostic window bytes 0, and `irq` low.
- R7: While `soft_rst` is high at a clock edge, bus writes and captures are ignored. The enable word keeps only bit 8 (variant 0), or bits [31:24], [9:2] and 11 (variants 1 and 2). All other words take their R6 values, `irq` goes low, and the diagnostic window bytes are kept.
- R8: In variant 0, addresses with A[12]=1 and A[11:2]=0 form a four-byte window. Byte A[1:0] is written from `wr_data[7:0]` and reads back zero-extended. In variants 1 and 2 this range is unmapped.
- R9: Event count 0 and event count 1 are separate words, and each reads back only its own last written value.
- R10: A capture pulse loads fault status with bit 0 = not uncorrectable, bit 3 = uncorrectable, [7:4] = `flt_dw`, [15:8] = `flt_synd`, bit 16 = multiple errors, and all other bits 0. It also loads fault address 0 and fault address 1 from `flt_addr0` and `flt_addr1`.
- R11: A capture drives `irq` high from the next cycle if it is uncorrectable, or if it is correctable and enable bit 1 was set. Otherwise `irq` keeps its value. `irq` changes only through R4, R6, R7 and this rule.
- R12: The multiple-errors bit of a capture is 1 exactly when bit 0 or bit 3 of the fault status was already set before that capture.
- R13: When a capture and a bus write to the fault status word share a cycle, the capture result is stored and the write is dropped, including its effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous reset that keeps some configuration fields |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid in the cycle of `rd_en` |
| flt_valid | input | 1 | Fault capture pulse |
| flt_uncorr | input | 1 | Captured error is uncorrectable |
| flt_dw | input | 4 | Double-word index of the fault |
| flt_synd | input | 8 | Syndrome of the fault |
| flt_addr0 | input | 32 | Value loaded into fault address 0 |
| flt_addr1 | input | 32 | Value loaded into fault address 1 |
| irq | output | 1 | Level interrupt |

## Verification
Two instances, variant 0 and variant 2, receive the same stimulus, so each write-mask, retention and window rule is seen against both flavours at once. The bench writes all-ones and alternating patterns to every index. This separates a masked field from a stored one and event count 0 from event count 1. It then writes to the fault address words and to the unmapped indexes and reads them back, to show that the writes went nowhere. The capture tests run in this order: a correctable capture with the interrupt enable set, a second capture that must flag multiple errors, a correctable capture with the enable cleared, an uncorrectable one, and a capture that collides with a status write. This order tells the interrupt condition, the pending detection and the collision priority apart.

// File: rtl/ecc_regbank_pkg.sv
package ecc_regbank_pkg;

    localparam int DATA_W   = 32;
    localparam int IDX_W    = 4;
    localparam int NUM_REGS = 9;

    typedef enum logic [IDX_W-1:0] {
        RI_ENABLE = 4'd0,
        RI_DELAY  = 4'd1,
        RI_FSTAT  = 4'd2,
        RI_VCFG   = 4'd3,
        RI_FADDR0 = 4'd4,
        RI_FADDR1 = 4'd5,
        RI_DIAG   = 4'd6,
        RI_EVC0   = 4'd7,
        RI_EVC1   = 4'd8
    } reg_idx_e;

    // fault status field positions
    localparam int FS_CE     = 0;
    localparam int FS_UE     = 3;
    localparam int FS_DW_LSB = 4;
    localparam int FS_SY_LSB = 8;
    localparam int FS_ME     = 16;

    localparam logic [DATA_W-1:0] DELAY_RST   = 32'h0000_0020;
    localparam logic [DATA_W-1:0] FADDR0_RST  = 32'h07C0_0000;
    localparam logic [DATA_W-1:0] DELAY_WMASK = 32'h7FFF_FFFF;

    typedef struct packed {
        logic [DATA_W-1:0] enable;
        logic [DATA_W-1:0] delay;
        logic [DATA_W-1:0] fstat;
        logic [DATA_W-1:0] vcfg;
        logic [DATA_W-1:0] faddr0;
        logic [DATA_W-1:0] faddr1;
        logic [DATA_W-1:0] diag;
        logic [DATA_W-1:0] evc0;
        logic [DATA_W-1:0] evc1;
        logic              irq;
    } regs_t;

    function automatic logic [DATA_W-1:0] variant_code(input int v);
        return DATA_W'(v) << 28;
    endfunction

    function automatic logic [DATA_W-1:0] enable_wmask(input int v);
        return (v == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    function automatic logic [DATA_W-1:0] enable_keep(input int v);
        return (v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

    function automatic regs_t base_state(input logic [DATA_W-1:0] en);
        regs_t s;
        s        = '0;
        s.enable = en;
        s.delay  = DELAY_RST;
        s.faddr0 = FADDR0_RST;
        return s;
    endfunction

endpackage

// File: rtl/ecc_addr_decode.sv
module ecc_addr_decode #(
    parameter int ADDR_W     = 13,
    parameter bit HAS_DIAG   = 1'b1,
    parameter int DIAG_BYTES = 4
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic                          reg_hit,
    output logic [3:0]                    reg_idx,
    output logic                          diag_hit,
    output logic [$clog2(DIAG_BYTES)-1:0] byte_sel
);
    localparam int WIN_BIT = ADDR_W - 1;
    localparam int SEL_W   = $clog2(DIAG_BYTES);

    always_comb begin
        reg_idx  = addr[5:2];
        reg_hit  = !addr[WIN_BIT] && (addr[WIN_BIT-1:6] == '0)
                   && (addr[5:2] <= 4'd8);
        diag_hit = HAS_DIAG && addr[WIN_BIT]
                   && (addr[WIN_BIT-1:SEL_W] == '0);
        byte_sel = addr[SEL_W-1:0];
    end
endmodule

// File: rtl/ecc_fault_merge.sv
module ecc_fault_merge
    import ecc_regbank_pkg::*;
(
    input  logic              cap_valid,
    input  logic              cap_uncorr,
    input  logic [3:0]        cap_dw,
    input  logic [7:0]        cap_synd,
    input  logic [DATA_W-1:0] prev_fstat,
    input  logic              corr_irq_en,
    output logic [DATA_W-1:0] new_fstat,
    output logic              raise_irq
);
    logic pending;

    always_comb begin
        pending                           = prev_fstat[FS_CE] | prev_fstat[FS_UE];
        new_fstat                         = '0;
        new_fstat[FS_CE]                  = !cap_uncorr;
        new_fstat[FS_UE]                  = cap_uncorr;
        new_fstat[FS_DW_LSB +: 4]         = cap_dw;
        new_fstat[FS_SY_LSB +: 8]         = cap_synd;
        new_fstat[FS_ME]                  = pending;
        raise_irq = cap_valid && (cap_uncorr || corr_irq_en);
    end
endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window #(
    parameter bit HAS_DIAG   = 1'b1,
    parameter int DIAG_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [$clog2(DIAG_BYTES)-1:0] sel,
    input  logic [7:0]                    wdata,
    output logic [7:0]                    rdata
);
    generate
        if (HAS_DIAG) begin : g_window
            logic [7:0] mem_d [DIAG_BYTES];
            logic [7:0] mem_q [DIAG_BYTES];

            always_comb begin
                mem_d = mem_q;
                if (wr) mem_d[sel] = wdata;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DIAG_BYTES; i++) mem_q[i] <= '0;
                end else begin
                    mem_q <= mem_d;
                end
            end

            assign rdata = mem_q[sel];
        end else begin : g_none
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, wr, sel, wdata};
            assign rdata = '0;
        end
    endgenerate
endmodule

// File: rtl/ecc_regbank.sv
module ecc_regbank
    import ecc_regbank_pkg::*;
#(
    parameter int VARIANT    = 0,
    parameter int ADDR_W     = 13,
    parameter int DIAG_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    input  logic              flt_valid,
    input  logic              flt_uncorr,
    input  logic [3:0]        flt_dw,
    input  logic [7:0]        flt_synd,
    input  logic [31:0]       flt_addr0,
    input  logic [31:0]       flt_addr1,
    output logic              irq
);
    localparam bit              HAS_DIAG = (VARIANT == 0);
    localparam int              SEL_W    = $clog2(DIAG_BYTES);
    localparam logic [DATA_W-1:0] CODE   = variant_code(VARIANT);
    localparam logic [DATA_W-1:0] EN_WM  = enable_wmask(VARIANT);
    localparam logic [DATA_W-1:0] EN_KEEP = enable_keep(VARIANT);

    regs_t             s_d, s_q;
    logic              reg_hit, diag_hit, raise_irq;
    logic [3:0]        reg_idx;
    logic [SEL_W-1:0]  byte_sel;
    logic [7:0]        diag_byte;
    logic [DATA_W-1:0] cap_fstat;
    logic [DATA_W-1:0] word_rd;

    ecc_addr_decode #(
        .ADDR_W    (ADDR_W),
        .HAS_DIAG  (HAS_DIAG),
        .DIAG_BYTES(DIAG_BYTES)
    ) u_dec (
        .addr    (addr),
        .reg_hit (reg_hit),
        .reg_idx (reg_idx),
        .diag_hit(diag_hit),
        .byte_sel(byte_sel)
    );

    ecc_fault_merge u_merge (
        .cap_valid  (flt_valid),
        .cap_uncorr (flt_uncorr),
        .cap_dw     (flt_dw),
        .cap_synd   (flt_synd),
        .prev_fstat (s_q.fstat),
        .corr_irq_en(s_q.enable[1]),
        .new_fstat  (cap_fstat),
        .raise_irq  (raise_irq)
    );

    ecc_diag_window #(
        .HAS_DIAG  (HAS_DIAG),
        .DIAG_BYTES(DIAG_BYTES)
    ) u_diag (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (wr_en && diag_hit && !soft_rst),
        .sel  (byte_sel),
        .wdata(wr_data[7:0]),
        .rdata(diag_byte)
    );

    // next-state logic: capture first, then bus write (capture wins on fstat)
    always_comb begin
        s_d = s_q;
        if (soft_rst) begin
            s_d = base_state(s_q.enable & EN_KEEP);
        end else begin
            if (flt_valid) begin
                s_d.fstat  = cap_fstat;
                s_d.faddr0 = flt_addr0;
                s_d.faddr1 = flt_addr1;
                if (raise_irq) s_d.irq = 1'b1;
            end
            if (wr_en && reg_hit) begin
                case (reg_idx_e'(reg_idx))
                    RI_ENABLE: s_d.enable = CODE | (wr_data & EN_WM);
                    RI_DELAY:  s_d.delay  = wr_data & DELAY_WMASK;
                    RI_FSTAT: begin
                        if (!flt_valid) begin
                            s_d.fstat = wr_data;
                            s_d.irq   = 1'b0;
                        end
                    end
                    RI_VCFG:   s_d.vcfg = wr_data;
                    RI_DIAG:   s_d.diag = wr_data;
                    RI_EVC0:   s_d.evc0 = wr_data;
                    RI_EVC1:   s_d.evc1 = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= base_state(CODE);
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_idx_e'(reg_idx))
            RI_ENABLE: word_rd = s_q.enable;
            RI_DELAY:  word_rd = s_q.delay;
            RI_FSTAT:  word_rd = s_q.fstat;
            RI_VCFG:   word_rd = s_q.vcfg;
            RI_FADDR0: word_rd = s_q.faddr0;
            RI_FADDR1: word_rd = s_q.faddr1;
            RI_DIAG:   word_rd = s_q.diag;
            RI_EVC0:   word_rd = s_q.evc0;
            RI_EVC1:   word_rd = s_q.evc1;
            default:   word_rd = '0;
        endcase
        rd_data = '0;
        if (rd_en) begin
            if (reg_hit)       rd_data = word_rd;
            else if (diag_hit) rd_data = {24'b0, diag_byte};
        end
    end

    assign irq = s_q.irq;
endmodule

// File: rtl/ecc_regbank_chk.sv
module ecc_regbank_chk #(
    parameter int VARIANT = 0,
    parameter int ADDR_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic              flt_valid,
    input logic              flt_uncorr,
    input logic              irq
);
    logic at_enable, at_delay, at_fstat;
    assign at_enable = (addr == ADDR_W'(0));
    assign at_delay  = (addr == ADDR_W'(4));
    assign at_fstat  = (addr == ADDR_W'(8));

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == 32'h0);

    assert_variant_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at_enable) |-> rd_data[31:28] == 4'(VARIANT));

    assert_delay_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at_delay) |-> !rd_data[31]);

    assert_status_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_fstat && !flt_valid && !soft_rst) |=> !irq);

    assert_soft_rst_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !irq);

    assert_ue_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_uncorr && !soft_rst) |=> irq);

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !soft_rst && !(wr_en && at_fstat)) |=> irq);

    assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !flt_valid) |=> !irq);
endmodule

bind ecc_regbank ecc_regbank_chk #(
    .VARIANT(VARIANT),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .flt_valid (flt_valid),
    .flt_uncorr(flt_uncorr),
    .irq       (irq)
);

// File: tb/ecc_regbank_tb_top.sv
module ecc_regbank_tb_top;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          flt_valid = 1'b0, flt_uncorr = 1'b0;
    logic [3:0]    flt_dw = '0;
    logic [7:0]    flt_synd = '0;
    logic [31:0]   flt_addr0 = '0, flt_addr1 = '0;
    logic [31:0]   rd_a, rd_b;
    logic          irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ecc_regbank #(.VARIANT(0), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_a),
        .flt_valid(flt_valid), .flt_uncorr(flt_uncorr), .flt_dw(flt_dw),
        .flt_synd(flt_synd), .flt_addr0(flt_addr0), .flt_addr1(flt_addr1),
        .irq(irq_a));

    ecc_regbank #(.VARIANT(2), .ADDR_W(AW)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_b),
        .flt_valid(flt_valid), .flt_uncorr(flt_uncorr), .flt_dw(flt_dw),
        .flt_synd(flt_synd), .flt_addr0(flt_addr0), .flt_addr1(flt_addr1),
        .irq(irq_b));

    // ---------------- reference model ----------------
    int          vcode [2] = '{0, 2};
    logic [31:0] m_reg [2][9];
    logic [7:0]  m_diag [2][4];
    logic        m_irq [2];

    task automatic model_por();
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 9; i++) m_reg[k][i] = 32'h0;
            m_reg[k][0] = 32'(vcode[k]) << 28;
            m_reg[k][1] = 32'h20;
            m_reg[k][4] = 32'h07C0_0000;
            for (int i = 0; i < 4; i++) m_diag[k][i] = 8'h0;
            m_irq[k] = 1'b0;
        end
    endtask

    function automatic logic [31:0] model_read(int k, logic [AW-1:0] a);
        if (a[12]) begin
            if (vcode[k] == 0 && a[11:2] == '0) return {24'h0, m_diag[k][a[1:0]]};
            return 32'h0;
        end
        if (a[11:6] != '0 || a[5:2] > 4'd8) return 32'h0;
        return m_reg[k][a[5:2]];
    endfunction

    task automatic model_update(int k);
        logic [31:0] old_en, old_fs, fs, keep;
        int v;
        v = vcode[k];
        if (soft_rst) begin
            keep = (v == 0) ? 32'h100 : 32'hFF00_0BFC;
            old_en = m_reg[k][0] & keep;
            for (int i = 0; i < 9; i++) m_reg[k][i] = 32'h0;
            m_reg[k][0] = old_en;
            m_reg[k][1] = 32'h20;
            m_reg[k][4] = 32'h07C0_0000;
            m_irq[k] = 1'b0;
            return;
        end
        old_en = m_reg[k][0];
        old_fs = m_reg[k][2];
        if (flt_valid) begin
            fs = 32'h0;
            fs[0] = !flt_uncorr;
            fs[3] = flt_uncorr;
            fs[7:4] = flt_dw;
            fs[15:8] = flt_synd;
            fs[16] = old_fs[0] | old_fs[3];
            m_reg[k][2] = fs;
            m_reg[k][4] = flt_addr0;
            m_reg[k][5] = flt_addr1;
            if (flt_uncorr || old_en[1]) m_irq[k] = 1'b1;
        end
        if (wr_en) begin
            if (addr[12]) begin
                if (v == 0 && addr[11:2] == '0) m_diag[k][addr[1:0]] = wr_data[7:0];
            end else if (addr[11:6] == '0) begin
                case (int'(addr[5:2]))
                    0: m_reg[k][0] = (v == 0) ? (wr_data & 32'h103)
                                              : ((32'(v) << 28) | (wr_data & 32'hBFF));
                    1: m_reg[k][1] = wr_data & 32'h7FFF_FFFF;
                    2: if (!flt_valid) begin m_reg[k][2] = wr_data; m_irq[k] = 1'b0; end
                    3, 6, 7, 8: m_reg[k][addr[5:2]] = wr_data;
                    default: ;
                endcase
            end
        end
    endtask

    // ---------------- checking ----------------
    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare reads, update model at posedge, compare irq
    task automatic step(string tag, logic we, logic re, logic [AW-1:0] a, logic [31:0] wd,
                        logic fv = 0, logic fu = 0, logic [3:0] dw = 0, logic [7:0] sy = 0,
                        logic [31:0] f0 = 0, logic [31:0] f1 = 0, logic sr = 0);
        @(negedge clk);
        wr_en = we; rd_en = re; addr = a; wr_data = wd;
        flt_valid = fv; flt_uncorr = fu; flt_dw = dw; flt_synd = sy;
        flt_addr0 = f0; flt_addr1 = f1; soft_rst = sr;
        #1;
        if (re) begin
            check(tag, $sformatf("v0 read %h", a), rd_a, model_read(0, a));
            check(tag, $sformatf("v2 read %h", a), rd_b, model_read(1, a));
        end else begin
            check(tag, "idle rd v0", rd_a, 32'h0);
        end
        @(posedge clk);
        model_update(0);
        model_update(1);
        #1;
        check(tag, "irq v0", {31'h0, irq_a}, {31'h0, m_irq[0]});
        check(tag, "irq v2", {31'h0, irq_b}, {31'h0, m_irq[1]});
    endtask

    task automatic wr(string tag, logic [AW-1:0] a, logic [31:0] d);
        step(tag, 1'b1, 1'b0, a, d);
    endtask

    task automatic rd(string tag, logic [AW-1:0] a);
        step(tag, 1'b0, 1'b1, a, 32'h0);
    endtask

    task automatic cap(string tag, logic fu, logic [3:0] dw, logic [7:0] sy,
                       logic [31:0] f0, logic [31:0] f1);
        step(tag, 1'b0, 1'b0, '0, 32'h0, 1'b1, fu, dw, sy, f0, f1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_por();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: power-on values, irq low
        for (int i = 0; i < 9; i++) rd("R6", AW'(i * 4));
        for (int i = 0; i < 4; i++) rd("R6", AW'(13'h1000 + i));

        // R2: enable write masks and variant code
        wr("R2", 13'h000, 32'hFFFF_FFFF);
        rd("R2", 13'h000);
        wr("R2", 13'h000, 32'h5555_5555);
        rd("R2", 13'h000);

        // R3: delay msb cleared
        wr("R3", 13'h004, 32'hFFFF_FFFF);
        rd("R3", 13'h004);
        wr("R3", 13'h004, 32'hA5A5_A5A5);
        rd("R3", 13'h004);

        // R9: separate event counters, plus plain words
        wr("R9", 13'h01C, 32'h1111_2222);
        wr("R9", 13'h020, 32'h3333_4444);
        rd("R9", 13'h01C);
        rd("R9", 13'h020);
        wr("R9", 13'h00C, 32'hCAFE_F00D);
        wr("R9", 13'h018, 32'hDEAD_BEEF);
        rd("R9", 13'h00C);
        rd("R9", 13'h018);

        // R5: fault address words ignore writes
        wr("R5", 13'h010, 32'h1234_5678);
        wr("R5", 13'h014, 32'h8765_4321);
        rd("R5", 13'h010);
        rd("R5", 13'h014);

        // R1: unmapped indexes and aliases read zero, writes go nowhere
        for (int i = 9; i < 16; i++) wr("R1", AW'(i * 4), 32'hFFFF_FFFF);
        for (int i = 9; i < 16; i++) rd("R1", AW'(i * 4));
        wr("R1", 13'h040, 32'h0BAD_0BAD);
        rd("R1", 13'h040);
        rd("R1", 13'h000);
        rd("R1", 13'h01C);

        // R8: diagnostic byte window
        for (int i = 0; i < 4; i++) wr("R8", AW'(13'h1000 + i), 32'hFFFF_FF00 | 32'(8'h3C + i * 17));
        for (int i = 0; i < 4; i++) rd("R8", AW'(13'h1000 + i));
        wr("R8", 13'h1004, 32'h77);
        rd("R8", 13'h1004);
        rd("R8", 13'h1000);

        // R10/R11: correctable capture with irq enable (bit 1 set earlier)
        wr("R11", 13'h000, 32'h0000_0103);
        cap("R10", 1'b0, 4'h5, 8'h9A, 32'hAAAA_0001, 32'hBBBB_0002);
        rd("R10", 13'h008);
        rd("R10", 13'h010);
        rd("R10", 13'h014);
        // R12: second capture while pending -> multiple errors
        cap("R12", 1'b1, 4'hC, 8'h11, 32'h0000_00F0, 32'h0000_0F00);
        rd("R12", 13'h008);
        // R4: status write clears irq and stores raw value
        wr("R4", 13'h008, 32'hFFFF_0000);
        rd("R4", 13'h008);
        // R12: no pending bit set -> no multiple errors
        wr("R4", 13'h008, 32'h0);
        // R11: correctable with enable bit 1 clear -> irq stays low
        wr("R11", 13'h000, 32'h0000_0100);
        cap("R11", 1'b0, 4'h1, 8'h22, 32'h1, 32'h2);
        rd("R12", 13'h008);
        // R11: uncorrectable raises irq regardless of enable
        cap("R11", 1'b1, 4'h2, 8'h33, 32'h3, 32'h4);
        step("R11", 1'b0, 1'b1, 13'h008, 32'h0);
        // R13: capture collides with status write
        wr("R4", 13'h008, 32'h0);
        step("R13", 1'b1, 1'b0, 13'h008, 32'h0000_0000, 1'b1, 1'b1, 4'h7, 8'h44, 32'h5, 32'h6);
        rd("R13", 13'h008);

        // R7: soft reset retention
        wr("R7", 13'h000, 32'hFFFF_FFFF);
        wr("R7", 13'h01C, 32'h99);
        step("R7", 1'b1, 1'b0, 13'h004, 32'h1234, 1'b0, 1'b0, 4'h0, 8'h0, 32'h0, 32'h0, 1'b1);
        for (int i = 0; i < 9; i++) rd("R7", AW'(i * 4));
        for (int i = 0; i < 4; i++) rd("R7", AW'(13'h1000 + i));

        step("R1", 1'b0, 1'b0, '0, 32'h0);
        finish_run();
    end
endmodule